// File: doc/BRIEF.md
# Pipeline Hazard and Branch-Freeze Controller

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that has no result forwarding and no branch prediction. It decodes the instruction word held in the fetch/decode latch and finds out which registers that instruction reads. It keeps a small scoreboard of the registers that instructions in execute and memory will still write. While any read register is pending, the instruction waits in decode: the program counter and the fetch/decode latch hold, and a bubble goes into the decode/execute latch. A producer that has reached write-back no longer blocks, because the register file writes in the first half of a cycle and reads in the second.

A conditional branch that reaches decode freezes fetch. The branch is issued, the wrongly fetched word is replaced by a NOP, and the program counter holds. In the next cycle the datapath compares the operands in execute and reports the outcome. The controller then redirects to the supplied target, or resumes fetch at the sequential address. A registered per-stage NOP mask marks every inserted bubble, so that external counters can leave stalled cycles out of stage utilization.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pc` equals RESET_PC (default 0) and `stage_nop` is 4'b1111. In that first cycle `ifid_load` and `idex_nop` are both 1.
- R2: With no hazard and no branch, `ifid_load` is 1 in each cycle. `pc` advances by PC_STEP (default 4) at the next edge, and `idex_nop` is 1 exactly when the decode latch holds an inserted NOP.
- R3: If a register read by the decode instruction is a pending destination of the instruction in execute or in memory, then `ifid_load` and `ifid_flush` are 0, `idex_nop` is 1, and `pc` keeps its value. A producer directly ahead costs two stall cycles, and one that is two ahead costs one.
- R4: A producer that has reached write-back causes no stall. An instruction three slots behind its producer issues at once.
- R5: A read of register 0 never stalls, even when register 0 is named as a destination.
- R6: Only register-writing instructions create pending destinations. Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Opcode 0 with funct 0x00 (sll), 0x02 (srl), 0x20 (add), 0x22 (sub), 0x24 (and), 0x25 (or) or 0x18 (mul) writes rd. Opcodes 0x08, 0x0A, 0x0B, 0x0C, 0x0D, 0x0F and 0x23 write rt. Store (0x2B), beq (0x04), other funct codes and other opcodes write nothing.
- R7: Read sets are as follows. sll and srl read only rt. The other opcode-0 forms and sw and beq read rs and rt. Immediate ALU ops and lw read only rs. lui and unknown opcodes read nothing.
- R8: A mul makes both rd and rd+1 (modulo 32) pending.
- R9: A beq in decode that is not stalled is issued into execute. In the same cycle `ifid_flush` is 1 and `pc` holds.
- R10: In the cycle in which the branch is in execute, `ex_br_taken`=1 loads `pc` with `ex_br_target` and flushes the decode latch again. `ex_br_taken`=0 sets `ifid_load` and advances `pc` by PC_STEP. In every other cycle `ex_br_taken` and `ex_br_target` have no effect.
- R11: `stage_nop` bit 0 flags that decode holds an inserted NOP. Bits 1, 2 and 3 flag the same for execute, memory and write-back. A bubble sent into decode/execute appears in bit 1 one cycle later, then moves up one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_instr | input | 32 | Instruction word in the fetch/decode latch |
| ex_br_taken | input | 1 | Branch outcome from execute |
| ex_br_target | input | PC_W | Branch target from execute |
| pc | output | PC_W | Registered fetch address |
| ifid_load | output | 1 | Fetch/decode latch captures the fetched word |
| ifid_flush | output | 1 | Fetch/decode latch loads a NOP |
| idex_nop | output | 1 | Decode/execute latch loads a NOP |
| stage_nop | output | 4 | Registered bubble flags for decode, execute, memory and write-back |

## Verification
A scoreboard entry that is stuck, lost or shifted shows at the ports in the cycle the dependent instruction reaches decode. It appears as a missing or extra cycle with `ifid_load` and `ifid_flush` both low, and as a wrong stall count for that distance between producer and consumer. A corrupt branch state shows within one cycle as `pc` not being held, redirected or stepped. It also shows as an extra or missing flush. Bubble-tracking faults show as a wrong bit in `stage_nop` one to three cycles after the bubble enters. For this reason, every output is compared against an independent pipeline model on every cycle.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int RIDX_W = 5;
  localparam int INSTR_W = 32;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_ADDI    = 6'h08;
  localparam logic [5:0] OP_SLTI    = 6'h0A;
  localparam logic [5:0] OP_SLTIU   = 6'h0B;
  localparam logic [5:0] OP_ANDI    = 6'h0C;
  localparam logic [5:0] OP_ORI     = 6'h0D;
  localparam logic [5:0] OP_LUI     = 6'h0F;
  localparam logic [5:0] OP_LW      = 6'h23;
  localparam logic [5:0] OP_SW      = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_MULW = 6'h18;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;

  typedef logic [RIDX_W-1:0] ridx_t;

  // lo/hi equal unless the producer writes a register pair
  typedef struct packed {
    logic  wr;
    ridx_t lo;
    ridx_t hi;
  } wdst_t;

  typedef struct packed {
    logic  use_s;
    ridx_t s;
    logic  use_t;
    ridx_t t;
    wdst_t dst;
    logic  branch;
  } idec_t;
endpackage

// File: rtl/phc_decode.sv
module phc_decode
  import phc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output idec_t              dec
);
  logic [5:0] op;
  logic [5:0] fn;
  ridx_t      rs, rt, rd;
  logic       pair;
  logic       unused_shamt;

  assign op = instr[31:26];
  assign rs = instr[25:21];
  assign rt = instr[20:16];
  assign rd = instr[15:11];
  assign fn = instr[5:0];
  assign unused_shamt = ^instr[10:6];

  always_comb begin
    dec  = '0;
    pair = 1'b0;
    dec.s = rs;
    dec.t = rt;
    case (op)
      OP_SPECIAL: begin
        dec.use_t = 1'b1;
        case (fn)
          FN_SLL, FN_SRL: begin
            dec.dst.wr = 1'b1;
            dec.dst.lo = rd;
          end
          FN_ADD, FN_SUB, FN_AND, FN_OR: begin
            dec.use_s  = 1'b1;
            dec.dst.wr = 1'b1;
            dec.dst.lo = rd;
          end
          FN_MULW: begin
            dec.use_s  = 1'b1;
            dec.dst.wr = 1'b1;
            dec.dst.lo = rd;
            pair       = 1'b1;
          end
          default: dec.use_s = 1'b1;
        endcase
      end
      OP_ADDI, OP_SLTI, OP_SLTIU, OP_ANDI, OP_ORI, OP_LW: begin
        dec.use_s  = 1'b1;
        dec.dst.wr = 1'b1;
        dec.dst.lo = rt;
      end
      OP_LUI: begin
        dec.dst.wr = 1'b1;
        dec.dst.lo = rt;
      end
      OP_SW: begin
        dec.use_s = 1'b1;
        dec.use_t = 1'b1;
      end
      OP_BEQ: begin
        dec.use_s  = 1'b1;
        dec.use_t  = 1'b1;
        dec.branch = 1'b1;
      end
      default: ;
    endcase
    dec.dst.hi = pair ? ridx_t'(dec.dst.lo + ridx_t'(1)) : dec.dst.lo;
  end
endmodule

// File: rtl/phc_scoreboard.sv
module phc_scoreboard
  import phc_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int CHECK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_nop,
  input  wdst_t            issue_dst,
  input  logic             use_s,
  input  ridx_t            src_s,
  input  logic             use_t,
  input  ridx_t            src_t,
  output logic             hazard,
  output logic [DEPTH-1:0] nop_q
);
  wdst_t            pend_q [CHECK];
  logic [CHECK-1:0] hit;
  wdst_t            entry;

  always_comb begin
    entry    = issue_dst;
    entry.wr = issue_dst.wr & ~issue_nop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < CHECK; k++) pend_q[k] <= '0;
    end else begin
      for (int k = CHECK - 1; k > 0; k--) pend_q[k] <= pend_q[k-1];
      pend_q[0] <= entry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) nop_q <= '1;
    else     nop_q <= {nop_q[DEPTH-2:0], issue_nop};
  end

  genvar g;
  generate
    for (g = 0; g < CHECK; g++) begin : g_cmp
      logic s_match, t_match;
      assign s_match = use_s && (src_s != '0) &&
                       ((src_s == pend_q[g].lo) || (src_s == pend_q[g].hi));
      assign t_match = use_t && (src_t != '0) &&
                       ((src_t == pend_q[g].lo) || (src_t == pend_q[g].hi));
      assign hit[g] = pend_q[g].wr && (s_match || t_match);
    end
    for (g = 1; g < DEPTH; g++) begin : g_nop_chk
      assert_nop_shift_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (nop_q[g] == $past(nop_q[g-1])));
    end
  endgenerate

  assign hazard = |hit;

  assert_r0_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    hazard |-> ((use_s && src_s != '0) || (use_t && src_t != '0)));

  initial begin
    assert_depth_ok_R3: assert (CHECK >= 1 && CHECK < DEPTH && DEPTH >= 2);
  end
endmodule

// File: rtl/phc_fetch.sv
module phc_fetch #(
  parameter int                PC_W     = 32,
  parameter logic [PC_W-1:0]   RESET_PC = '0,
  parameter int unsigned       PC_STEP  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  input  logic            br_issue,
  output logic [PC_W-1:0] pc,
  output logic            br_in_ex
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= RESET_PC;
      br_in_ex <= 1'b0;
    end else begin
      if (redirect)     pc <= target;
      else if (advance) pc <= pc + STEP;
      br_in_ex <= br_issue;
    end
  end

  assert_single_resolve_R10: assert property (@(posedge clk) disable iff (rst)
    br_in_ex |=> !br_in_ex);
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import phc_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter int unsigned     PC_STEP     = 4,
  parameter int              TRACK_DEPTH = 3,
  parameter int              PEND_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [31:0]            id_instr,
  input  logic                   ex_br_taken,
  input  logic [PC_W-1:0]        ex_br_target,
  output logic [PC_W-1:0]        pc,
  output logic                   ifid_load,
  output logic                   ifid_flush,
  output logic                   idex_nop,
  output logic [TRACK_DEPTH:0]   stage_nop
);
  idec_t                  dec;
  logic                   id_nop_q;
  logic                   id_live;
  logic                   hazard;
  logic                   br_in_ex;
  logic                   br_issue;
  logic                   redirect;
  logic                   advance;
  logic [TRACK_DEPTH-1:0] trk_nop;

  phc_decode u_dec (
    .instr (id_instr),
    .dec   (dec)
  );

  phc_scoreboard #(
    .DEPTH (TRACK_DEPTH),
    .CHECK (PEND_STAGES)
  ) u_sb (
    .clk       (clk),
    .rst       (rst),
    .issue_nop (idex_nop),
    .issue_dst (dec.dst),
    .use_s     (dec.use_s & id_live),
    .src_s     (dec.s),
    .use_t     (dec.use_t & id_live),
    .src_t     (dec.t),
    .hazard    (hazard),
    .nop_q     (trk_nop)
  );

  phc_fetch #(
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC),
    .PC_STEP  (PC_STEP)
  ) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .redirect (redirect),
    .target   (ex_br_target),
    .br_issue (br_issue),
    .pc       (pc),
    .br_in_ex (br_in_ex)
  );

  assign id_live = ~id_nop_q;

  always_comb begin
    ifid_load  = 1'b0;
    ifid_flush = 1'b0;
    idex_nop   = 1'b0;
    br_issue   = 1'b0;
    redirect   = 1'b0;
    advance    = 1'b0;
    if (br_in_ex) begin
      idex_nop = 1'b1;
      if (ex_br_taken) begin
        ifid_flush = 1'b1;
        redirect   = 1'b1;
      end else begin
        ifid_load = 1'b1;
        advance   = 1'b1;
      end
    end else if (hazard) begin
      idex_nop = 1'b1;
    end else if (id_live && dec.branch) begin
      ifid_flush = 1'b1;
      br_issue   = 1'b1;
    end else begin
      ifid_load = 1'b1;
      advance   = 1'b1;
      idex_nop  = ~id_live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             id_nop_q <= 1'b1;
    else if (ifid_flush) id_nop_q <= 1'b1;
    else if (ifid_load)  id_nop_q <= 1'b0;
  end

  assign stage_nop = {trk_nop, id_nop_q};

  assert_stall_holds_pc_R3: assert property (@(posedge clk) disable iff (rst)
    (!ifid_load && !ifid_flush) |=> $stable(pc));

  assert_branch_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (ifid_flush && !br_in_ex) |=> (br_in_ex && $stable(pc)));

  assert_flush_empties_id_R9: assert property (@(posedge clk) disable iff (rst)
    ifid_flush |=> stage_nop[0]);

  assert_taken_target_R10: assert property (@(posedge clk) disable iff (rst)
    (br_in_ex && ex_br_taken) |=> (pc == $past(ex_br_target)));

  assert_fallthrough_R10: assert property (@(posedge clk) disable iff (rst)
    (br_in_ex && !ex_br_taken) |=> (pc == PC_W'($past(pc) + PC_W'(PC_STEP))));

  assert_bubble_enters_R11: assert property (@(posedge clk) disable iff (rst)
    idex_nop |=> stage_nop[1]);
endmodule

// File: tb/pipe_hazard_ctl_tb_top.sv
module pipe_hazard_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] id_instr = '0;
  logic        ex_br_taken = 1'b0;
  logic [31:0] ex_br_target = '0;
  logic [31:0] pc;
  logic        ifid_load, ifid_flush, idex_nop;
  logic [3:0]  stage_nop;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_hazard_ctl dut_i (
    .clk(clk), .rst(rst), .id_instr(id_instr), .ex_br_taken(ex_br_taken),
    .ex_br_target(ex_br_target), .pc(pc), .ifid_load(ifid_load),
    .ifid_flush(ifid_flush), .idex_nop(idex_nop), .stage_nop(stage_nop)
  );

  typedef struct packed {
    logic ua; logic [4:0] a; logic ub; logic [4:0] b;
    logic wr; logic [4:0] d; logic pr; logic br;
  } mdec_t;

  logic [31:0] prog [64];
  logic [31:0] ifid_q;
  logic [31:0] m_pc;
  logic [3:0]  m_nop;
  logic        m_wr [2];
  logic [4:0]  m_d  [2];
  logic        m_pr [2];
  logic        m_br;
  int vectors = 0, miscompares = 0, obs_stall = 0, obs_flush = 0;
  bit done = 0;

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic mdec_t mdec(logic [31:0] w);
    mdec_t r = '0;
    r.a = w[25:21];
    r.b = w[20:16];
    if (w[31:26] == 6'h00) begin
      r.ub = 1;
      if (w[5:0] == 6'h00 || w[5:0] == 6'h02) begin r.wr = 1; r.d = w[15:11]; end
      else begin
        r.ua = 1;
        if (w[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h18}) begin r.wr = 1; r.d = w[15:11]; end
        if (w[5:0] == 6'h18) r.pr = 1;
      end
    end else if (w[31:26] inside {6'h08, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h23}) begin
      r.ua = 1; r.wr = 1; r.d = w[20:16];
    end else if (w[31:26] == 6'h0F) begin
      r.wr = 1; r.d = w[20:16];
    end else if (w[31:26] == 6'h2B) begin
      r.ua = 1; r.ub = 1;
    end else if (w[31:26] == 6'h04) begin
      r.ua = 1; r.ub = 1; r.br = 1;
    end
    return r;
  endfunction

  function automatic bit conflict(logic u, logic [4:0] s);
    bit c = 0;
    if (u && s != 0)
      for (int k = 0; k < 2; k++) begin
        logic [4:0] nxt = m_d[k] + 5'd1;
        if (m_wr[k] && (s == m_d[k] || (m_pr[k] && s == nxt))) c = 1;
      end
    return c;
  endfunction

  function automatic logic [31:0] rnd_instr();
    logic [4:0] x = 5'($urandom % 8), y = 5'($urandom % 8), z = 5'($urandom % 8);
    logic [15:0] im = 16'($urandom);
    case ($urandom % 14)
      0:  return enc_r(6'h20, x, y, z);
      1:  return enc_r(6'h22, x, y, z);
      2:  return enc_r(6'h24, x, y, z);
      3:  return enc_r(6'h25, x, y, z);
      4:  return enc_r(6'h18, x, y, z);
      5:  return enc_r(6'h00, x, y, z);
      6:  return enc_r(6'h02, x, y, z);
      7:  return enc_i(6'h08, x, y, im);
      8:  return enc_i(($urandom % 2) ? 6'h0C : 6'h0D, x, y, im);
      9:  return enc_i(($urandom % 2) ? 6'h0A : 6'h0B, x, y, im);
      10: return enc_i(6'h0F, x, y, im);
      11: return enc_i(6'h23, x, y, im);
      12: return enc_i(6'h2B, x, y, im);
      default: return ($urandom % 2) ? enc_i(6'h04, x, y, im) : enc_i(6'h3F, x, y, im);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_nop = 4'hF; m_br = 0; ifid_q = '0;
    for (int k = 0; k < 2; k++) begin m_wr[k] = 0; m_d[k] = '0; m_pr[k] = 0; end
    obs_stall = 0; obs_flush = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic clear_prog();
    for (int k = 0; k < 64; k++) prog[k] = '0;
  endtask

  task automatic step(input logic tk, input logic [31:0] tg);
    mdec_t d;
    bit live, haz;
    logic e_load, e_flush, e_inop, brn;
    logic [31:0] pc_n;
    string tag;
    id_instr = ifid_q; ex_br_taken = tk; ex_br_target = tg;
    #1;
    d = mdec(ifid_q);
    live = !m_nop[0];
    haz = live && (conflict(d.ua, d.a) || conflict(d.ub, d.b));
    e_load = 0; e_flush = 0; e_inop = 0; brn = 0; pc_n = m_pc;
    if (m_br) begin
      e_inop = 1; tag = "R10";
      if (tk) begin e_flush = 1; pc_n = tg; end
      else begin e_load = 1; pc_n = m_pc + 4; end
    end else if (haz) begin
      e_inop = 1; tag = "R3";
    end else if (live && d.br) begin
      e_flush = 1; brn = 1; tag = "R9";
    end else begin
      e_load = 1; pc_n = m_pc + 4; e_inop = !live; tag = "R2";
    end
    chk(pc == m_pc, tag, "pc", pc, m_pc);
    chk(stage_nop == m_nop, "R11", "stage_nop", 32'(stage_nop), 32'(m_nop));
    chk(ifid_load == e_load, tag, "ifid_load", 32'(ifid_load), 32'(e_load));
    chk(ifid_flush == e_flush, tag, "ifid_flush", 32'(ifid_flush), 32'(e_flush));
    chk(idex_nop == e_inop, tag, "idex_nop", 32'(idex_nop), 32'(e_inop));
    if (!ifid_load && !ifid_flush) obs_stall++;
    if (ifid_flush) obs_flush++;
    // advance the reference pipeline
    if (e_flush) ifid_q = '0;
    else if (e_load) ifid_q = prog[m_pc[7:2]];
    m_nop[3] = m_nop[2];
    m_nop[2] = m_nop[1];
    m_nop[1] = e_inop;
    if (e_flush) m_nop[0] = 1;
    else if (e_load) m_nop[0] = 0;
    m_wr[1] = m_wr[0]; m_d[1] = m_d[0]; m_pr[1] = m_pr[0];
    m_wr[0] = !e_inop && d.wr; m_d[0] = d.d; m_pr[0] = d.pr;
    m_br = brn;
    m_pc = pc_n;
    @(negedge clk);
  endtask

  task automatic run_directed(input string req, input int ncyc, input logic tk,
                              input logic [31:0] tg, input int exp_stall, input int exp_flush);
    do_reset();
    for (int c = 0; c < ncyc; c++) step(tk, tg);
    chk(obs_stall == exp_stall, req, "stall cycles", 32'(obs_stall), 32'(exp_stall));
    chk(obs_flush == exp_flush, req, "flush cycles", 32'(obs_flush), 32'(exp_flush));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    clear_prog();
    do_reset();
    #1;
    chk(pc == 32'h0, "R1", "reset pc", pc, 32'h0);
    chk(stage_nop == 4'hF, "R1", "reset stage_nop", 32'(stage_nop), 32'hF);
    chk(ifid_load == 1'b1 && idex_nop == 1'b1, "R1", "first cycle load/nop",
        32'({ifid_load, idex_nop}), 32'h3);

    // R3: adjacent producer costs two stalls, one slot apart costs one
    clear_prog();
    prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd1);
    prog[1] = enc_r(6'h20, 5'd1, 5'd1, 5'd2);
    run_directed("R3", 14, 1'b0, 32'h0, 2, 0);
    clear_prog();
    prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd1);
    prog[2] = enc_r(6'h20, 5'd1, 5'd0, 5'd2);
    run_directed("R3", 14, 1'b0, 32'h0, 1, 0);
    // R4: producer in write-back does not block
    clear_prog();
    prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd1);
    prog[3] = enc_r(6'h20, 5'd1, 5'd1, 5'd2);
    run_directed("R4", 14, 1'b0, 32'h0, 0, 0);
    // R5: register 0 as destination and source
    clear_prog();
    prog[0] = enc_i(6'h08, 5'd0, 5'd0, 16'd1);
    prog[1] = enc_r(6'h20, 5'd0, 5'd0, 5'd2);
    run_directed("R5", 14, 1'b0, 32'h0, 0, 0);
    // R6: store and unknown opcode leave no pending destination
    clear_prog();
    prog[0] = enc_i(6'h2B, 5'd2, 5'd3, 16'd0);
    prog[1] = enc_r(6'h20, 5'd3, 5'd3, 5'd4);
    prog[2] = enc_i(6'h3F, 5'd0, 5'd5, 16'd0);
    prog[3] = enc_r(6'h20, 5'd5, 5'd5, 5'd6);
    run_directed("R6", 14, 1'b0, 32'h0, 0, 0);
    // R7: shift ignores rs, lui reads nothing, lw reads rs
    clear_prog();
    prog[0] = enc_i(6'h08, 5'd0, 5'd5, 16'd1);
    prog[1] = enc_r(6'h00, 5'd5, 5'd0, 5'd2);
    prog[2] = enc_i(6'h0F, 5'd5, 5'd6, 16'd1);
    run_directed("R7", 14, 1'b0, 32'h0, 0, 0);
    clear_prog();
    prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd1);
    prog[1] = enc_i(6'h23, 5'd1, 5'd2, 16'd0);
    run_directed("R7", 14, 1'b0, 32'h0, 2, 0);
    // R8: mul makes rd+1 pending
    clear_prog();
    prog[0] = enc_r(6'h18, 5'd1, 5'd2, 5'd8);
    prog[1] = enc_r(6'h20, 5'd9, 5'd0, 5'd3);
    run_directed("R8", 14, 1'b0, 32'h0, 2, 0);
    // R9/R10: taken branch flushes twice, not-taken once
    clear_prog();
    prog[0] = enc_i(6'h04, 5'd0, 5'd0, 16'd4);
    run_directed("R10", 14, 1'b1, 32'h40, 0, 2);
    run_directed("R9", 14, 1'b0, 32'h40, 0, 1);
    // R10: outcome inputs ignored with no branch in execute
    clear_prog();
    run_directed("R10", 10, 1'b1, 32'h80, 0, 0);
    chk(pc == 32'd40, "R10", "pc after ignored outcome", pc, 32'd40);

    // mixed random streams against the reference pipeline
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 64; k++) prog[k] = rnd_instr();
      do_reset();
      for (int c = 0; c < 600; c++)
        step(1'($urandom % 2), {24'h0, 6'($urandom % 64), 2'b00});
    end
    finish_run();
  end
endmodule